// File: doc/BRIEF.md
# Bank Strobe Select Decoder

This block turns a two-bit bank address, a three-bit grouping code and four per-byte enables into registered row-strobe and column-strobe enables for four memory banks. A memory sequencer raises `accessActive` for the length of a read or write and `refreshActive` for the length of a refresh. The decoder drives `rasOut` and `casOut` for the cycle after each strobe. It also reports on `scrubEn` whether the present grouping code asks refresh cycles to perform error scrubbing.

The grouping code selects one of three groupings. In the first, every access strobes all four banks. In the second, banks are strobed in pairs chosen by the upper bank bit. In the third, a single bank is chosen by both bank bits. A fourth code keeps the all-bank grouping but turns scrubbing off, so refresh strobes rows only. The bank address is captured on the first cycle of an access and held until the access ends.

Top module: `bank_strobe_dec`

## Requirements
- R1: While `rstN` is low, and on the first clock after its release with both strobes low, `rasOut` and `casOut` are 0.
- R2: With `cfgMode` = 3'b000, an access drives `rasOut` = 4'b1111 and ignores both bank bits.
- R3: With `cfgMode` = 3'b001, an access drives `rasOut` = 4'b0011 when `bankAddr[1]` = 0 and 4'b1100 when it is 1; `bankAddr[0]` has no effect.
- R4: With `cfgMode` = 3'b010, an access drives a one-hot `rasOut` with bit `bankAddr` set (00 gives bit 0, 11 gives bit 3).
- R5: With `cfgMode` = 3'b011, an access drives `rasOut` = 4'b1111, and `scrubEn` is 0.
- R6: During an access, `casOut[i]` is 1 only when `rasOut[i]` is selected and `byteEn[i]` is 1.
- R7: During a refresh, `rasOut` = 4'b1111 whatever the bank bits. When `scrubEn` is 1 (codes 000, 001, 010), `casOut` = 4'b1111 whatever `byteEn` is.
- R8: During a refresh with `scrubEn` = 0, `casOut` = 0.
- R9: Codes 3'b100 to 3'b111 behave exactly like 3'b000, including `scrubEn` = 1.
- R10: The bank address is sampled on the first cycle `accessActive` is high and held while it stays high. A change of `bankAddr` during an access has no effect on the outputs.
- R11: When `accessActive` and `refreshActive` are both high in a cycle, the refresh result (R7/R8) is driven.
- R12: Outputs are registered. They reflect the strobes of the previous clock cycle and are 0 after a cycle with neither strobe high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accessActive | input | 1 | High for the whole of an access |
| refreshActive | input | 1 | High for the whole of a refresh |
| cfgMode | input | 3 | Grouping and scrubbing code |
| bankAddr | input | 2 | Bank address bits |
| byteEn | input | 4 | Per-byte column-strobe enables, active high |
| rasOut | output | 4 | Registered row-strobe enables, one per bank |
| casOut | output | 4 | Registered column-strobe enables, one per bank |
| scrubEn | output | 1 | High when refreshes should scrub |

## Verification
An access request and a refresh request can arrive in the same cycle. When they collide, the bank grouping and the byte enables must give way to the all-bank refresh pattern. The bench raises both strobes together under a scrubbing code and under the row-only code, with byte enables that differ from the refresh pattern. It expects all four row strobes in both cases, with column strobes all on in the first case and all off in the second.

// File: rtl/bank_strobe_pkg.sv
package bank_strobe_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int CFG_W = 3;

  typedef enum logic [CFG_W-1:0] {
    GRP_ALL      = 3'b000,
    GRP_PAIR     = 3'b001,
    GRP_SINGLE   = 3'b010,
    GRP_ALL_ROWS = 3'b011
  } grpMode_e;

  typedef struct packed {
    logic              accessEn;
    logic              refreshEn;
    logic [BANK_W-1:0] bank;
  } strobeCtl_t;
endpackage

// File: rtl/bank_strobe_ctl.sv
module bank_strobe_ctl
  import bank_strobe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accessActive,
  input  logic              refreshActive,
  input  logic [BANK_W-1:0] bankAddr,
  output strobeCtl_t        ctl
);
  logic              accessPrev;
  logic [BANK_W-1:0] bankHeld;
  logic              accessStart;

  assign accessStart = accessActive && !accessPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accessPrev <= 1'b0;
      bankHeld   <= '0;
    end else begin
      accessPrev <= accessActive;
      if (accessStart) bankHeld <= bankAddr;
    end
  end

  always_comb begin
    ctl.accessEn  = accessActive;
    ctl.refreshEn = refreshActive;
    ctl.bank      = accessStart ? bankAddr : bankHeld;
  end

  // R10
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accessActive && accessPrev) |-> (ctl.bank == bankHeld));
endmodule

// File: rtl/bank_strobe_dp.sv
module bank_strobe_dp
  import bank_strobe_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeCtl_t           ctl,
  input  logic [CFG_W-1:0]     cfgMode,
  input  logic [NUM_BANKS-1:0] byteEn,
  output logic [NUM_BANKS-1:0] rasOut,
  output logic [NUM_BANKS-1:0] casOut,
  output logic                 scrubEn
);
  grpMode_e             modeEff;
  logic [NUM_BANKS-1:0] selMask;
  logic [NUM_BANKS-1:0] rasNext;
  logic [NUM_BANKS-1:0] casNext;

  // Reserved codes fold onto the all-bank code.
  assign modeEff = cfgMode[CFG_W-1] ? GRP_ALL : grpMode_e'(cfgMode);
  assign scrubEn = (modeEff != GRP_ALL_ROWS);

  always_comb begin
    selMask = '0;
    unique case (modeEff)
      GRP_PAIR: begin
        for (int i = 0; i < NUM_BANKS; i++)
          selMask[i] = (i / 2 == int'(ctl.bank[BANK_W-1]));
      end
      GRP_SINGLE: selMask[ctl.bank] = 1'b1;
      default:    selMask = '1;
    endcase
  end

  always_comb begin
    if (ctl.refreshEn) begin
      rasNext = '1;
      casNext = scrubEn ? '1 : '0;
    end else if (ctl.accessEn) begin
      rasNext = selMask;
      casNext = selMask & byteEn;
    end else begin
      rasNext = '0;
      casNext = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasOut <= '0;
      casOut <= '0;
    end else begin
      rasOut <= rasNext;
      casOut <= casNext;
    end
  end

  // R6
  cas_within_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    (casOut & ~rasOut) == '0);
  // R7
  refresh_all_rows_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.refreshEn |=> (rasOut == '1));
  // R8
  rowonly_refresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.refreshEn && !scrubEn) |=> (casOut == '0));
  // R4
  single_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accessEn && !ctl.refreshEn && cfgMode == GRP_SINGLE) |=> ($countones(rasOut) == 1));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.accessEn && !ctl.refreshEn) |=> (rasOut == '0 && casOut == '0));
endmodule

// File: rtl/bank_strobe_dec.sv
module bank_strobe_dec
  import bank_strobe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accessActive,
  input  logic       refreshActive,
  input  logic [2:0] cfgMode,
  input  logic [1:0] bankAddr,
  input  logic [3:0] byteEn,
  output logic [3:0] rasOut,
  output logic [3:0] casOut,
  output logic       scrubEn
);
  strobeCtl_t ctl;

  bank_strobe_ctl u_ctl (
    .clk(clk), .rstN(rstN), .accessActive(accessActive),
    .refreshActive(refreshActive), .bankAddr(bankAddr), .ctl(ctl)
  );

  bank_strobe_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgMode(cfgMode), .byteEn(byteEn),
    .rasOut(rasOut), .casOut(casOut), .scrubEn(scrubEn)
  );

  // R10
  held_access_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accessActive && $past(accessActive) && !refreshActive && !$past(refreshActive)
     && $stable(cfgMode) && $stable(byteEn)) |=> $stable(rasOut));
endmodule

// File: tb/bank_strobe_dec_tb.sv
module bank_strobe_dec_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       accessActive = 1'b0;
  logic       refreshActive = 1'b0;
  logic [2:0] cfgMode = 3'b000;
  logic [1:0] bankAddr = 2'b00;
  logic [3:0] byteEn = 4'h0;
  logic [3:0] rasOut, casOut;
  logic       scrubEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int cycles = 0;

  always #4 clk = ~clk;

  bank_strobe_dec u_dut (
    .clk(clk), .rstN(rstN), .accessActive(accessActive), .refreshActive(refreshActive),
    .cfgMode(cfgMode), .bankAddr(bankAddr), .byteEn(byteEn),
    .rasOut(rasOut), .casOut(casOut), .scrubEn(scrubEn)
  );

  // vector: cfg(3) bank(2) byteEn(4) acc(1) ref(1) expRas(4) expCas(4) expScrub(1)
  localparam int NV = 18;
  localparam logic [19:0] VEC [NV] = '{
    {3'b000, 2'd2, 4'hF, 1'b1, 1'b0, 4'hF, 4'hF, 1'b1}, // R2
    {3'b000, 2'd1, 4'h5, 1'b1, 1'b0, 4'hF, 4'h5, 1'b1}, // R6
    {3'b001, 2'd0, 4'hF, 1'b1, 1'b0, 4'h3, 4'h3, 1'b1}, // R3
    {3'b001, 2'd1, 4'hF, 1'b1, 1'b0, 4'h3, 4'h3, 1'b1}, // R3
    {3'b001, 2'd2, 4'hA, 1'b1, 1'b0, 4'hC, 4'h8, 1'b1}, // R3 R6
    {3'b001, 2'd3, 4'hF, 1'b1, 1'b0, 4'hC, 4'hC, 1'b1}, // R3
    {3'b010, 2'd0, 4'hF, 1'b1, 1'b0, 4'h1, 4'h1, 1'b1}, // R4
    {3'b010, 2'd1, 4'hF, 1'b1, 1'b0, 4'h2, 4'h2, 1'b1}, // R4
    {3'b010, 2'd2, 4'hB, 1'b1, 1'b0, 4'h4, 4'h0, 1'b1}, // R4 R6
    {3'b010, 2'd3, 4'hF, 1'b1, 1'b0, 4'h8, 4'h8, 1'b1}, // R4
    {3'b011, 2'd1, 4'h6, 1'b1, 1'b0, 4'hF, 4'h6, 1'b0}, // R5
    {3'b000, 2'd0, 4'h0, 1'b0, 1'b1, 4'hF, 4'hF, 1'b1}, // R7
    {3'b010, 2'd3, 4'h0, 1'b0, 1'b1, 4'hF, 4'hF, 1'b1}, // R7
    {3'b011, 2'd0, 4'hF, 1'b0, 1'b1, 4'hF, 4'h0, 1'b0}, // R8
    {3'b110, 2'd3, 4'hF, 1'b1, 1'b0, 4'hF, 4'hF, 1'b1}, // R9
    {3'b101, 2'd1, 4'h0, 1'b0, 1'b1, 4'hF, 4'hF, 1'b1}, // R9
    {3'b001, 2'd1, 4'h0, 1'b1, 1'b1, 4'hF, 4'hF, 1'b1}, // R11
    {3'b011, 2'd2, 4'hF, 1'b1, 1'b1, 4'hF, 4'h0, 1'b0}  // R11
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    accessActive = 1'b0;
    refreshActive = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 ras in reset", rasOut, 4'h0);
    check("R1 cas in reset", casOut, 4'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ras after reset", rasOut, 4'h0);

    for (int v = 0; v < NV; v++) begin
      idle();
      cfgMode = VEC[v][19:17];
      bankAddr = VEC[v][16:15];
      byteEn = VEC[v][14:11];
      accessActive = VEC[v][10];
      refreshActive = VEC[v][9];
      @(negedge clk);
      check($sformatf("R2-table ras v%0d", v), rasOut, VEC[v][8:5]);
      check($sformatf("R6-table cas v%0d", v), casOut, VEC[v][4:1]);
      check($sformatf("R5-table scrub v%0d", v), {3'b0, scrubEn}, {3'b0, VEC[v][0]});
    end

    // R12: output not yet changed before the edge; zero after idle
    idle();
    cfgMode = 3'b010; bankAddr = 2'd1; byteEn = 4'hF; accessActive = 1'b1;
    #1;
    check("R12 ras before edge", rasOut, 4'h0);
    @(negedge clk);
    check("R10 ras at start", rasOut, 4'h2);
    // R10: change bank mid-access, no effect
    bankAddr = 2'd3;
    @(negedge clk);
    check("R10 ras held", rasOut, 4'h2);
    check("R10 cas held", casOut, 4'h2);
    @(negedge clk);
    check("R10 ras still held", rasOut, 4'h2);
    idle();
    check("R12 ras idle", rasOut, 4'h0);
    check("R12 cas idle", casOut, 4'h0);
    accessActive = 1'b1;
    @(negedge clk);
    check("R10 new access bank", rasOut, 4'h8);
    idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule